// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control engine that saves and restores processor state around an interrupt on a 16-bit core with a user mode and a supervisor mode. It holds the status word, the program counter and the live stack pointer. It also holds two save registers, one for the user stack pointer and one for the supervisor stack pointer. The status word carries the privilege bit at [15], where 1 means user, the priority level at [10:8] and the condition codes at [2:0].

On an interrupt the block switches to the supervisor stack if the core is in user mode. It then pushes the status word and then the program counter, rewrites the status word for supervisor execution at the new priority, and loads the program counter indirectly from a vector table. On a return request it pops the program counter and then the status word. If the restored word shows user mode, it switches back to the user stack.

A return request made in user mode is refused. It reads nothing from the stack. Instead it raises a one-cycle exception pulse and enters the handler for internal vector 0x00 without changing the current priority level. Memory is reached through a single-port interface: one access per cycle, with read data arriving one cycle after the request.

Top module: `trap_frame_seq`

## Requirements
- R1: After a synchronous reset, psr_o, pc_o and sp_o hold their reset parameter values, busy is 0 and mem_req is 0.
- R2: An interrupt accepted in user mode (psr_o[15]=1) copies sp_o into the saved user pointer and loads sp_o from the saved supervisor pointer before any push.
- R3: Entry writes the old status word to address sp-1 and then the old pc to address sp-2, decrementing the pointer before each write, so sp_o ends 2 below its start.
- R4: When entry completes, psr_o[15]=0, psr_o[10:8] equals the serviced priority, psr_o[2:0]=0, and all other bits keep their previous values.
- R5: Entry reads address 0x0100 plus the 8-bit vector and loads the returned word into pc_o.
- R6: A return in supervisor mode reads pc_o from address sp and then the status word from address sp+1, leaving sp_o 2 higher.
- R7: If the popped status word has bit 15 set, sp_o is reloaded from the saved user pointer. Otherwise it keeps the popped pointer value.
- R8: An interrupt taken in supervisor mode does no pointer swap and pushes onto the current stack, so nested entries and returns unwind in order.
- R9: A return requested in user mode performs no stack read. exc_pulse goes high for exactly one cycle, and the block runs the entry sequence with vector 0x00 and the current priority.
- R10: busy rises on the cycle after an accepted request and stays high for 4 cycles on entry and 3 on return. Requests seen while busy have no effect.
- R11: When irq_req and ret_req are high in the same idle cycle, the interrupt is taken and the return is dropped.
- R12: mem_req is high only while busy, mem_we only together with mem_req, and each read's data is consumed on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request, sampled when idle |
| irq_vec | input | 8 | Interrupt vector |
| irq_prio | input | 3 | Priority of the interrupt |
| ret_req | input | 1 | Return-from-interrupt request, sampled when idle |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| busy | output | 1 | A sequence is in progress |
| exc_pulse | output | 1 | One-cycle privilege-violation exception |
| psr_o | output | 16 | Processor status word |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Live stack pointer |

## Verification
Two cases are hard to reach from the ports: a return whose popped status word selects supervisor mode, and a swap back to a user pointer that the bench can never write. The bench reaches the first by rewriting the status word in its own stack model between entry and return. It reaches the second only through complete user-to-supervisor-to-user round trips. It sweeps every vector at every priority. Every sixteenth vector gets a nested entry on top, and the bench checks how the frame unwinds. Further requests are driven during busy windows to show they are ignored.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int WORD_W   = 16;
    localparam int VEC_W    = 8;
    localparam int PRIO_W   = 3;
    localparam int PRIV_BIT = 15;
    localparam int PRIO_LO  = 8;
    localparam int CC_W     = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSR,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_VEC_LD,
        ST_POP_PC,
        ST_POP_PSR,
        ST_POP_DONE
    } seq_state_e;

    typedef struct packed {
        logic swap_in;
        logic sp_dec;
        logic sp_inc;
        logic psr_enter;
        logic pc_load;
        logic psr_load;
    } reg_ctl_t;

    typedef struct packed {
        logic  req;
        logic  we;
        word_t addr;
        word_t wdata;
    } mem_cmd_t;

    function automatic logic is_user(word_t psr);
        return psr[PRIV_BIT];
    endfunction

    function automatic prio_t prio_of(word_t psr);
        return psr[PRIO_LO +: PRIO_W];
    endfunction

    function automatic word_t psr_on_entry(word_t cur, prio_t lvl);
        word_t r;
        r = cur;
        r[PRIV_BIT] = 1'b0;
        r[PRIO_LO +: PRIO_W] = lvl;
        r[CC_W-1:0] = '0;
        return r;
    endfunction

    function automatic word_t table_addr(word_t base, vec_t v);
        return base + word_t'(v);
    endfunction

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_req,
    input  vec_t       irq_vec,
    input  prio_t      irq_prio,
    input  logic       ret_req,
    input  logic       user_mode,
    input  prio_t      cur_prio,
    output seq_state_e state,
    output reg_ctl_t   ctl,
    output vec_t       vec_q,
    output prio_t      prio_q,
    output logic       exc_pulse
);

    seq_state_e state_n;
    logic       idle;

    assign idle = (state == ST_IDLE);

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE: begin
                if (irq_req)      state_n = ST_PUSH_PSR;
                else if (ret_req) state_n = user_mode ? ST_PUSH_PSR : ST_POP_PC;
            end
            ST_PUSH_PSR: state_n = ST_PUSH_PC;
            ST_PUSH_PC:  state_n = ST_VEC_RD;
            ST_VEC_RD:   state_n = ST_VEC_LD;
            ST_VEC_LD:   state_n = ST_IDLE;
            ST_POP_PC:   state_n = ST_POP_PSR;
            ST_POP_PSR:  state_n = ST_POP_DONE;
            ST_POP_DONE: state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl           = '0;
        ctl.swap_in   = idle && user_mode && (irq_req || ret_req);
        ctl.sp_dec    = (state == ST_PUSH_PSR) || (state == ST_PUSH_PC);
        ctl.psr_enter = (state == ST_PUSH_PC);
        ctl.sp_inc    = (state == ST_POP_PC) || (state == ST_POP_PSR);
        ctl.pc_load   = (state == ST_VEC_LD) || (state == ST_POP_PSR);
        ctl.psr_load  = (state == ST_POP_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            vec_q     <= '0;
            prio_q    <= '0;
            exc_pulse <= 1'b0;
        end else begin
            state     <= state_n;
            exc_pulse <= 1'b0;
            if (idle) begin
                if (irq_req) begin
                    vec_q  <= irq_vec;
                    prio_q <= irq_prio;
                end else if (ret_req && user_mode) begin
                    vec_q     <= '0;
                    prio_q    <= cur_prio;
                    exc_pulse <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
#(
    parameter logic [15:0] RESET_PC  = 16'h0200,
    parameter logic [15:0] RESET_PSR = 16'h8A5A,
    parameter logic [15:0] RESET_USP = 16'hFE00,
    parameter logic [15:0] RESET_SSP = 16'h3000
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_ctl_t ctl,
    input  prio_t    prio_q,
    input  word_t    mem_rdata,
    output word_t    psr,
    output word_t    pc,
    output word_t    sp
);

    word_t saved_usp;
    word_t saved_ssp;

    always_ff @(posedge clk) begin
        if (rst) begin
            psr       <= RESET_PSR;
            pc        <= RESET_PC;
            sp        <= RESET_USP;
            saved_usp <= RESET_USP;
            saved_ssp <= RESET_SSP;
        end else begin
            if (ctl.swap_in) begin
                saved_usp <= sp;
                sp        <= saved_ssp;
            end else if (ctl.sp_dec) begin
                sp <= sp - word_t'(1);
            end else if (ctl.sp_inc) begin
                sp <= sp + word_t'(1);
            end else if (ctl.psr_load && is_user(mem_rdata)) begin
                sp <= saved_usp;
            end

            if (ctl.psr_enter)     psr <= psr_on_entry(psr, prio_q);
            else if (ctl.psr_load) psr <= mem_rdata;

            if (ctl.pc_load) pc <= mem_rdata;
        end
    end

endmodule

// File: rtl/trap_memif.sv
module trap_memif
    import trap_pkg::*;
#(
    parameter logic [15:0] VEC_BASE = 16'h0100
) (
    input  seq_state_e state,
    input  word_t      sp,
    input  word_t      psr,
    input  word_t      pc,
    input  vec_t       vec_q,
    output mem_cmd_t   cmd
);

    always_comb begin
        cmd = '0;
        case (state)
            ST_PUSH_PSR: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = sp - word_t'(1);
                cmd.wdata = psr;
            end
            ST_PUSH_PC: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = sp - word_t'(1);
                cmd.wdata = pc;
            end
            ST_VEC_RD: begin
                cmd.req  = 1'b1;
                cmd.addr = table_addr(VEC_BASE, vec_q);
            end
            ST_POP_PC, ST_POP_PSR: begin
                cmd.req  = 1'b1;
                cmd.addr = sp;
            end
            default: cmd = '0;
        endcase
    end

endmodule

// File: rtl/trap_frame_seq.sv
module trap_frame_seq
    import trap_pkg::*;
#(
    parameter logic [15:0] VEC_BASE  = 16'h0100,
    parameter logic [15:0] RESET_PC  = 16'h0200,
    parameter logic [15:0] RESET_PSR = 16'h8A5A,
    parameter logic [15:0] RESET_USP = 16'hFE00,
    parameter logic [15:0] RESET_SSP = 16'h3000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_req,
    input  logic [7:0]  irq_vec,
    input  logic [2:0]  irq_prio,
    input  logic        ret_req,
    input  logic [15:0] mem_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        busy,
    output logic        exc_pulse,
    output logic [15:0] psr_o,
    output logic [15:0] pc_o,
    output logic [15:0] sp_o
);

    seq_state_e state;
    reg_ctl_t   ctl;
    vec_t       vec_q;
    prio_t      prio_q;
    word_t      psr, pc, sp;
    mem_cmd_t   cmd;

    trap_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_prio  (irq_prio),
        .ret_req   (ret_req),
        .user_mode (is_user(psr)),
        .cur_prio  (prio_of(psr)),
        .state     (state),
        .ctl       (ctl),
        .vec_q     (vec_q),
        .prio_q    (prio_q),
        .exc_pulse (exc_pulse)
    );

    trap_regs #(
        .RESET_PC  (RESET_PC),
        .RESET_PSR (RESET_PSR),
        .RESET_USP (RESET_USP),
        .RESET_SSP (RESET_SSP)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .prio_q    (prio_q),
        .mem_rdata (mem_rdata),
        .psr       (psr),
        .pc        (pc),
        .sp        (sp)
    );

    trap_memif #(
        .VEC_BASE (VEC_BASE)
    ) u_memif (
        .state (state),
        .sp    (sp),
        .psr   (psr),
        .pc    (pc),
        .vec_q (vec_q),
        .cmd   (cmd)
    );

    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;
    assign busy      = (state != ST_IDLE);
    assign psr_o     = psr;
    assign pc_o      = pc;
    assign sp_o      = sp;

endmodule

// File: rtl/trap_frame_seq_chk.sv
module trap_frame_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        busy,
    input logic        exc_pulse,
    input logic [15:0] psr_o,
    input logic [15:0] pc_o,
    input logic [15:0] sp_o
);

    // R9: the exception pulse lasts one cycle
    p_exc_width_r9: assert property (@(posedge clk) disable iff (rst)
        exc_pulse |=> !exc_pulse);

    // R9: the exception comes with an entry sequence in progress
    p_exc_busy_r9: assert property (@(posedge clk) disable iff (rst)
        exc_pulse |-> busy);

    // R12: no memory traffic while idle
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R12: a write is always a request
    p_we_with_req_r12: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R3: after each push the pointer equals the address written
    p_push_moves_sp_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (sp_o == $past(mem_addr)));

    // R10: architectural state holds while idle with no request accepted
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> ($stable(psr_o) && $stable(pc_o) && $stable(sp_o)));

endmodule

bind trap_frame_seq trap_frame_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .exc_pulse (exc_pulse),
    .psr_o     (psr_o),
    .pc_o      (pc_o),
    .sp_o      (sp_o)
);

// File: tb/tb_trap_frame_seq.sv
module tb_trap_frame_seq;

    localparam logic [15:0] P_PC   = 16'h0200;
    localparam logic [15:0] P_PSR  = 16'h8A5A;
    localparam logic [15:0] P_USP  = 16'hFE00;
    localparam logic [15:0] P_SSP  = 16'h3000;
    localparam logic [15:0] STK_LO = 16'h2E00;
    localparam logic [15:0] KEEP   = 16'h78F8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic [2:0]  irq_prio = '0;
    logic        ret_req = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_req, mem_we, busy, exc_pulse;
    logic [15:0] mem_addr, mem_wdata, psr_o, pc_o, sp_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;
    int n_wr = 0, n_stk_rd = 0, n_vec_rd = 0, n_bad = 0, exc_seen = 0;
    logic [15:0] last_vec_addr = '0;
    logic [15:0] stk [0:511];

    always #2 clk = ~clk;

    trap_frame_seq dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_prio(irq_prio), .ret_req(ret_req), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .exc_pulse(exc_pulse),
        .psr_o(psr_o), .pc_o(pc_o), .sp_o(sp_o)
    );

    function automatic logic [15:0] target(input logic [7:0] v);
        return 16'h4000 + {4'h0, v, 4'h0};
    endfunction

    function automatic logic [15:0] enter_psr(input logic [15:0] old, input logic [2:0] p);
        return (old & KEEP) | {5'b0, p, 8'h00};
    endfunction

    function automatic logic in_stk(input logic [15:0] a);
        return (a >= STK_LO) && (a < P_SSP);
    endfunction

    always @(posedge clk) begin
        cyc_cnt++;
        if (exc_pulse) exc_seen++;
        if (mem_req) begin
            if (mem_we) begin
                n_wr++;
                if (in_stk(mem_addr)) stk[mem_addr[8:0]] <= mem_wdata;
                else n_bad++;
            end else if (mem_addr[15:8] == 8'h01) begin
                n_vec_rd++;
                last_vec_addr <= mem_addr;
                mem_rdata <= target(mem_addr[7:0]);
            end else if (in_stk(mem_addr)) begin
                n_stk_rd++;
                mem_rdata <= stk[mem_addr[8:0]];
            end else begin
                n_bad++;
                mem_rdata <= 16'hDEAD;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_op(input logic i_irq, input logic i_ret, input logic [7:0] v,
                          input logic [2:0] p, input logic poke, output int cyc);
        @(negedge clk);
        irq_req = i_irq; ret_req = i_ret; irq_vec = v; irq_prio = p;
        n_wr = 0; n_stk_rd = 0; n_vec_rd = 0; exc_seen = 0;
        @(negedge clk);
        irq_req = 1'b0; ret_req = 1'b0;
        cyc = 0;
        while (busy && cyc < 20) begin
            cyc++;
            if (poke && cyc >= 2) begin
                irq_req = 1'b1; ret_req = 1'b1; irq_vec = 8'hFF; irq_prio = 3'h7;
            end else begin
                irq_req = 1'b0; ret_req = 1'b0;
            end
            @(negedge clk);
        end
        irq_req = 1'b0; ret_req = 1'b0;
    endtask

    initial begin
        int cyc;
        logic [15:0] ep, ep2;
        logic [7:0]  v2;
        for (int i = 0; i < 512; i++) stk[i] = 16'h0000;
        do_reset();

        // R1: reset state
        check(psr_o == P_PSR, "R1 psr", psr_o, P_PSR);
        check(pc_o == P_PC, "R1 pc", pc_o, P_PC);
        check(sp_o == P_USP, "R1 sp", sp_o, P_USP);
        check(busy == 1'b0 && mem_req == 1'b0, "R1 idle", {14'b0, busy, mem_req}, 16'h0);

        // Sweep: every vector at every priority, user entry and return
        for (int v = 0; v < 256; v++) begin
            for (int p = 0; p < 8; p++) begin
                ep = enter_psr(P_PSR, 3'(p));
                run_op(1'b1, 1'b0, 8'(v), 3'(p), 1'b0, cyc);
                check(sp_o == P_SSP - 16'd2, "R2 sp after user entry", sp_o, P_SSP - 16'd2);
                check(stk[9'h1FF] == P_PSR, "R3 psr pushed first", stk[9'h1FF], P_PSR);
                check(stk[9'h1FE] == P_PC, "R3 pc pushed second", stk[9'h1FE], P_PC);
                check(psr_o == ep, "R4 entry psr", psr_o, ep);
                check(pc_o == target(8'(v)), "R5 handler pc", pc_o, target(8'(v)));
                check(last_vec_addr == 16'h0100 + 16'(v), "R5 table address", last_vec_addr, 16'h0100 + 16'(v));
                check(cyc == 4, "R10 entry cycles", 16'(cyc), 16'd4);
                check(n_wr == 2 && n_vec_rd == 1 && n_bad == 0, "R12 entry accesses",
                      16'(n_wr), 16'd2);

                if ((v % 16) == 0 && p == 5) begin
                    // R8: nested entry from supervisor mode
                    v2 = 8'(v) ^ 8'h55;
                    ep2 = enter_psr(ep, 3'(7 - p));
                    run_op(1'b1, 1'b0, v2, 3'(7 - p), 1'b0, cyc);
                    check(sp_o == P_SSP - 16'd4, "R8 nested sp", sp_o, P_SSP - 16'd4);
                    check(stk[9'h1FD] == ep, "R8 nested psr push", stk[9'h1FD], ep);
                    check(stk[9'h1FC] == target(8'(v)), "R8 nested pc push", stk[9'h1FC], target(8'(v)));
                    check(psr_o == ep2, "R8 nested psr", psr_o, ep2);
                    check(pc_o == target(v2), "R8 nested handler", pc_o, target(v2));
                    run_op(1'b0, 1'b1, 8'h00, 3'h0, 1'b0, cyc);
                    check(pc_o == target(8'(v)), "R6 inner return pc", pc_o, target(8'(v)));
                    check(psr_o == ep, "R6 inner return psr", psr_o, ep);
                    check(sp_o == P_SSP - 16'd2, "R7 supervisor pointer kept", sp_o, P_SSP - 16'd2);
                end

                run_op(1'b0, 1'b1, 8'h00, 3'h0, (v % 7) == 3, cyc);
                check(pc_o == P_PC, "R6 return pc", pc_o, P_PC);
                check(psr_o == P_PSR, "R6 return psr", psr_o, P_PSR);
                check(sp_o == P_USP, "R7 user pointer restored", sp_o, P_USP);
                check(cyc == 3, "R10 return cycles", 16'(cyc), 16'd3);
                check(n_stk_rd == 2 && n_wr == 0 && exc_seen == 0, "R12 return accesses",
                      16'(n_stk_rd), 16'd2);
            end
        end

        // R9: return requested in user mode
        run_op(1'b0, 1'b1, 8'h33, 3'h6, 1'b0, cyc);
        check(exc_seen == 1, "R9 exception pulse count", 16'(exc_seen), 16'd1);
        check(n_stk_rd == 0, "R9 no stack pops", 16'(n_stk_rd), 16'd0);
        check(last_vec_addr == 16'h0100, "R9 vector 0x00", last_vec_addr, 16'h0100);
        check(pc_o == target(8'h00), "R9 handler pc", pc_o, target(8'h00));
        check(psr_o == enter_psr(P_PSR, 3'h2), "R9 priority kept", psr_o, enter_psr(P_PSR, 3'h2));
        check(sp_o == P_SSP - 16'd2, "R9 frame on supervisor stack", sp_o, P_SSP - 16'd2);
        run_op(1'b0, 1'b1, 8'h00, 3'h0, 1'b0, cyc);
        check(exc_seen == 0 && psr_o == P_PSR, "R9 return after exception", psr_o, P_PSR);

        // R10: requests during busy are ignored
        run_op(1'b1, 1'b0, 8'h21, 3'h4, 1'b1, cyc);
        check(pc_o == target(8'h21), "R10 poke entry pc", pc_o, target(8'h21));
        check(psr_o == enter_psr(P_PSR, 3'h4), "R10 poke entry psr", psr_o, enter_psr(P_PSR, 3'h4));
        check(cyc == 4 && n_wr == 2, "R10 poke no extra sequence", 16'(cyc), 16'd4);
        @(negedge clk);
        check(!busy, "R10 idle after poke", {15'b0, busy}, 16'h0);
        run_op(1'b0, 1'b1, 8'h00, 3'h0, 1'b0, cyc);

        // R11: simultaneous requests in user mode, interrupt wins
        run_op(1'b1, 1'b1, 8'h9C, 3'h3, 1'b0, cyc);
        check(exc_seen == 0, "R11 no exception", 16'(exc_seen), 16'd0);
        check(pc_o == target(8'h9C), "R11 interrupt taken", pc_o, target(8'h9C));
        // R11: simultaneous requests in supervisor mode, interrupt wins
        run_op(1'b1, 1'b1, 8'h11, 3'h5, 1'b0, cyc);
        check(sp_o == P_SSP - 16'd4 && pc_o == target(8'h11), "R11 nested over return",
              sp_o, P_SSP - 16'd4);
        run_op(1'b0, 1'b1, 8'h00, 3'h0, 1'b0, cyc);
        run_op(1'b0, 1'b1, 8'h00, 3'h0, 1'b0, cyc);
        check(sp_o == P_USP && pc_o == P_PC, "R11 unwound", sp_o, P_USP);

        // R7: popped status word selects supervisor, pointer not swapped
        run_op(1'b1, 1'b0, 8'h40, 3'h1, 1'b0, cyc);
        @(negedge clk);
        stk[9'h1FF] = 16'h0345;
        run_op(1'b0, 1'b1, 8'h00, 3'h0, 1'b0, cyc);
        check(psr_o == 16'h0345, "R7 edited psr restored", psr_o, 16'h0345);
        check(sp_o == P_SSP, "R7 stays on supervisor stack", sp_o, P_SSP);
        check(pc_o == P_PC, "R6 pc from edited frame", pc_o, P_PC);

        do_reset();
        check(psr_o == P_PSR && sp_o == P_USP, "R1 second reset", sp_o, P_USP);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc_cnt >= 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule